// File: doc/BRIEF.md
# Oversampled Bit-Clock Recovery and NRZI Decoder

This block sits behind a tone or level demodulator that delivers one hard symbol decision per sample, at several samples per bit. A free-running signed phase accumulator advances once per sample and wraps at the bit rate. Every raw symbol edge pulls the accumulator toward zero by a gain that is stronger while the carrier detector reports no lock and weaker once it does. The bit instant is the sample on which the accumulator wraps from positive to negative. On that sample the block takes a two-of-three vote over the newest raw symbols.

The voted symbol can optionally go through a 17-stage self-synchronising descrambler with taps at stages 17 and 12. The result is then NRZI-decoded: an unchanged symbol yields a one and a changed symbol yields a zero. Each decoded bit appears with a single-clock valid strobe and is passed to a frame parser downstream.

Three rate settings choose 8, 4 or 32 samples per bit. The fast setting also uses its own locked gain.

Top module: `bcr_bit_recovery`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the phase accumulator, the raw symbol history, the last recovered symbol, `bit_out` and `bit_vld`, and loads all 17 descrambler stages with ones.
- R2: The phase accumulator changes only on samples with `sym_vld` high. On each such sample it first adds 2^32/N, wrapping at 32 bits. N is set by `rate_sel`: 00 gives 8, 01 gives 4, 10 gives 32, and 11 gives 8.
- R3: A bit instant is a strobed sample on which the accumulator is positive before the addition and negative after it. `bit_vld` is high for exactly the one clock that follows each bit instant and is low at all other times.
- R4: At a bit instant the recovered symbol is 1 when at least two of the three newest raw symbols are 1. Those three symbols include the one on the current sample.
- R5: On a strobed sample where the current raw symbol differs from the previous one, the accumulator is set to the post-addition value times a Q1.15 gain, truncated toward zero. The gain is 16384 while `locked` is low. While `locked` is high it is 29164 for `rate_sel` 01 and 24248 for all other settings.
- R6: With `descr_en` high, the descrambled output at a bit instant is stage 17 XOR stage 12 XOR the voted symbol. The register then shifts by one, and the voted (still scrambled) symbol enters stage 1.
- R7: `bit_out` is 1 when the recovered symbol equals the one recovered at the previous bit instant and 0 otherwise. The first comparison after reset is made against 0.
- R8: With `descr_en` low, the voted symbol is used directly and the descrambler register holds its contents, so descrambling resumes from the held state when it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | Sample strobe, one clock per oversampled symbol |
| sym_in | input | 1 | Hard symbol decision for this sample |
| locked | input | 1 | Carrier-detect lock indication, selects the gentler phase gain |
| rate_sel | input | 2 | Rate setting: 00 N=8, 01 N=4, 10 N=32, 11 N=8 |
| descr_en | input | 1 | Enables the self-synchronising descrambler |
| bit_out | output | 1 | Decoded data bit |
| bit_vld | output | 1 | One-clock strobe marking a new `bit_out` |

## Verification
A wrong phase value does not show up at the ports right away. It shifts the sample on which the next wrap occurs, so the error first appears as a `bit_vld` pulse one or more samples early or late. After that the stream contains an extra or missing decoded bit, usually within one bit period. A corrupted descrambler stage flips decoded bits starting at the next bit instant and keeps doing so for up to 17 bit instants, because the corruption has to shift out of the register. A bad NRZI history bit shows up on exactly one decoded bit.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  typedef enum logic [1:0] {
    RATE_MID   = 2'd0,
    RATE_FAST  = 2'd1,
    RATE_SLOW  = 2'd2,
    RATE_SPARE = 2'd3
  } rate_e;

  localparam int PH_W      = 32;
  localparam int GAIN_FRAC = 15;
  localparam int GAIN_W    = GAIN_FRAC + 1;
  localparam int PROD_W    = PH_W + GAIN_W + 1;

  // Increment that makes the accumulator wrap once every spb samples.
  function automatic logic [PH_W-1:0] phase_step(input int unsigned spb);
    logic [PH_W:0] full;
    logic [PH_W:0] div;
    full = '0;
    full[PH_W] = 1'b1;
    div = (PH_W + 1)'(spb);
    return PH_W'(full / div);
  endfunction

  // Signed value times an unsigned Q1.15 gain, rounded toward zero.
  function automatic logic signed [PH_W-1:0] scale_toward_zero(
      input logic signed [PH_W-1:0] v,
      input logic [GAIN_W-1:0]      g);
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] bias;
    prod = v * $signed({1'b0, g});
    bias = '0;
    bias[GAIN_FRAC-1:0] = '1;
    if (prod < 0) prod = prod + bias;
    return prod[PH_W+GAIN_FRAC-1:GAIN_FRAC];
  endfunction

  function automatic logic [PH_W-1:0] magnitude(input logic signed [PH_W-1:0] v);
    return (v < 0) ? PH_W'(-v) : PH_W'(v);
  endfunction

endpackage

// File: rtl/bcr_phase_track.sv
module bcr_phase_track
  import bcr_pkg::*;
#(
  parameter int unsigned SPB_MID        = 8,
  parameter int unsigned SPB_FAST       = 4,
  parameter int unsigned SPB_SLOW       = 32,
  parameter logic [GAIN_W-1:0] GAIN_FREE      = 16'd16384,
  parameter logic [GAIN_W-1:0] GAIN_LOCK      = 16'd24248,
  parameter logic [GAIN_W-1:0] GAIN_LOCK_FAST = 16'd29164
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sample_en,
  input  rate_e                  mode,
  input  logic                   locked,
  input  logic                   retune,
  output logic signed [PH_W-1:0] phase_q,
  output logic signed [PH_W-1:0] phase_nxt,
  output logic                   bit_instant
);

  localparam logic [PH_W-1:0] STEP_MID  = phase_step(SPB_MID);
  localparam logic [PH_W-1:0] STEP_FAST = phase_step(SPB_FAST);
  localparam logic [PH_W-1:0] STEP_SLOW = phase_step(SPB_SLOW);

  logic [PH_W-1:0]   step;
  logic [GAIN_W-1:0] gain;

  always_comb begin
    unique case (mode)
      RATE_FAST: step = STEP_FAST;
      RATE_SLOW: step = STEP_SLOW;
      default:   step = STEP_MID;
    endcase
  end

  always_comb begin
    if (!locked)                gain = GAIN_FREE;
    else if (mode == RATE_FAST) gain = GAIN_LOCK_FAST;
    else                        gain = GAIN_LOCK;
  end

  assign phase_nxt   = phase_q + $signed(step);
  assign bit_instant = (phase_q > 0) && (phase_nxt < 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (sample_en) begin
      if (retune) phase_q <= scale_toward_zero(phase_nxt, gain);
      else        phase_q <= phase_nxt;
    end
  end

endmodule

// File: rtl/bcr_descrambler.sv
module bcr_descrambler #(
  parameter int LEN    = 17,
  parameter int TAP_HI = 16,
  parameter int TAP_LO = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           advance,
  input  logic           enable,
  input  logic           din,
  output logic           dout,
  output logic [LEN-1:0] state_q
);

  assign dout = enable ? (state_q[TAP_HI] ^ state_q[TAP_LO] ^ din) : din;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '1;
    end else if (advance && enable) begin
      state_q <= {state_q[LEN-2:0], din};
    end
  end

endmodule

// File: rtl/bcr_nrzi.sv
module bcr_nrzi (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic chip,
  output logic bit_out,
  output logic bit_vld,
  output logic last_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out <= 1'b0;
      bit_vld <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      bit_vld <= strobe;
      if (strobe) begin
        bit_out <= (chip == last_q);
        last_q  <= chip;
      end
    end
  end

endmodule

// File: rtl/bcr_bit_recovery.sv
module bcr_bit_recovery
  import bcr_pkg::*;
#(
  parameter int unsigned SPB_MID  = 8,
  parameter int unsigned SPB_FAST = 4,
  parameter int unsigned SPB_SLOW = 32,
  parameter int VOTE     = 3,
  parameter int SCR_LEN  = 17,
  parameter int SCR_TAPA = 16,
  parameter int SCR_TAPB = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_vld,
  input  logic       sym_in,
  input  logic       locked,
  input  logic [1:0] rate_sel,
  input  logic       descr_en,
  output logic       bit_out,
  output logic       bit_vld
);

  localparam int VOTE_MIN = VOTE / 2 + 1;

  logic [VOTE-1:0]        raw_q;
  logic [VOTE-1:0]        raw_nxt;
  logic                   retune;
  logic                   voted;
  logic signed [PH_W-1:0] phase_q;
  logic signed [PH_W-1:0] phase_nxt;
  logic                   bit_instant;
  logic                   take_bit;
  logic                   chip;
  logic [SCR_LEN-1:0]     lfsr_q;
  logic                   last_sym;

  assign raw_nxt  = {raw_q[VOTE-2:0], sym_in};
  assign retune   = sym_vld && (raw_nxt[1] ^ raw_nxt[0]);
  assign voted    = ($countones(raw_nxt) >= VOTE_MIN);
  assign take_bit = sym_vld && bit_instant;

  always_ff @(posedge clk) begin
    if (rst)          raw_q <= '0;
    else if (sym_vld) raw_q <= raw_nxt;
  end

  bcr_phase_track #(
    .SPB_MID (SPB_MID),
    .SPB_FAST(SPB_FAST),
    .SPB_SLOW(SPB_SLOW)
  ) u_phase (
    .clk        (clk),
    .rst        (rst),
    .sample_en  (sym_vld),
    .mode       (rate_e'(rate_sel)),
    .locked     (locked),
    .retune     (retune),
    .phase_q    (phase_q),
    .phase_nxt  (phase_nxt),
    .bit_instant(bit_instant)
  );

  bcr_descrambler #(
    .LEN   (SCR_LEN),
    .TAP_HI(SCR_TAPA),
    .TAP_LO(SCR_TAPB)
  ) u_descr (
    .clk    (clk),
    .rst    (rst),
    .advance(take_bit),
    .enable (descr_en),
    .din    (voted),
    .dout   (chip),
    .state_q(lfsr_q)
  );

  bcr_nrzi u_nrzi (
    .clk    (clk),
    .rst    (rst),
    .strobe (take_bit),
    .chip   (chip),
    .bit_out(bit_out),
    .bit_vld(bit_vld),
    .last_q (last_sym)
  );

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
  import bcr_pkg::*;
#(
  parameter int unsigned SPB_MID  = 8,
  parameter int unsigned SPB_FAST = 4,
  parameter int unsigned SPB_SLOW = 32,
  parameter int SCR_LEN = 17
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   sym_vld,
  input logic [1:0]             rate_sel,
  input logic                   descr_en,
  input logic                   bit_instant,
  input logic                   retune,
  input logic signed [PH_W-1:0] phase_q,
  input logic signed [PH_W-1:0] phase_nxt,
  input logic [SCR_LEN-1:0]     lfsr_q,
  input logic                   bit_vld
);

  logic [PH_W-1:0] exp_step;
  always_comb begin
    case (rate_sel)
      2'd1:    exp_step = phase_step(SPB_FAST);
      2'd2:    exp_step = phase_step(SPB_SLOW);
      default: exp_step = phase_step(SPB_MID);
    endcase
  end

  assert_vld_follows_instant_R3: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && bit_instant) |=> bit_vld);

  assert_vld_has_cause_R3: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> $past(sym_vld && bit_instant));

  assert_vld_single_R3: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld);

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !sym_vld |=> $stable(phase_q));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && !retune) |=> (phase_q == $past(phase_q) + $signed($past(exp_step))));

  assert_retune_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && retune) |=> (magnitude(phase_q) <= magnitude($past(phase_nxt))));

  assert_descr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(sym_vld && bit_instant && descr_en) |=> $stable(lfsr_q));

endmodule

bind bcr_bit_recovery bcr_checker #(
  .SPB_MID (SPB_MID),
  .SPB_FAST(SPB_FAST),
  .SPB_SLOW(SPB_SLOW),
  .SCR_LEN (SCR_LEN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sym_vld    (sym_vld),
  .rate_sel   (rate_sel),
  .descr_en   (descr_en),
  .bit_instant(bit_instant),
  .retune     (retune),
  .phase_q    (phase_q),
  .phase_nxt  (phase_nxt),
  .lfsr_q     (lfsr_q),
  .bit_vld    (bit_vld)
);

// File: tb/tb_bcr_bit_recovery.sv
module tb_bcr_bit_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 120000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_vld = 1'b0;
  logic       sym_in = 1'b0;
  logic       locked = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       descr_en = 1'b0;
  logic       bit_out;
  logic       bit_vld;

  int n_tests = 0;
  int n_fail = 0;
  string cur_req = "R1";

  bit exp_q[$];

  // Reference state, written from the requirements.
  int ref_ph;
  bit [2:0] ref_raw;
  int ref_lfsr;
  bit ref_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcr_bit_recovery dut (
    .clk(clk), .rst(rst), .sym_vld(sym_vld), .sym_in(sym_in),
    .locked(locked), .rate_sel(rate_sel), .descr_en(descr_en),
    .bit_out(bit_out), .bit_vld(bit_vld)
  );

  function automatic int spb_of(input logic [1:0] r);
    case (r)
      2'd1: return 4;
      2'd2: return 32;
      default: return 8;
    endcase
  endfunction

  function automatic longint gain_of(input logic lk, input logic [1:0] r);
    if (!lk) return 16384;
    if (r == 2'd1) return 29164;
    return 24248;
  endfunction

  task automatic ref_reset();
    ref_ph = 0; ref_raw = '0; ref_lfsr = 32'h1FFFF; ref_last = 1'b0;
    exp_q.delete();
  endtask

  // R2 advance, R3 instant, R4 vote, R6/R8 descrambler, R7 NRZI, R5 retune
  task automatic ref_sample(input bit s);
    int prev, nxt, ones;
    bit v, o;
    prev = ref_ph;
    nxt = ref_ph + int'(64'h1_0000_0000 / spb_of(rate_sel));
    ref_raw = {ref_raw[1:0], s};
    if (prev > 0 && nxt < 0) begin
      ones = ref_raw[0] + ref_raw[1] + ref_raw[2];
      v = (ones >= 2);
      if (descr_en) begin
        o = ref_lfsr[16] ^ ref_lfsr[11] ^ v;
        ref_lfsr = ((ref_lfsr << 1) | int'(v)) & 32'h1FFFF;
      end else begin
        o = v;
      end
      exp_q.push_back(o == ref_last);
      ref_last = o;
    end
    if (ref_raw[1] != ref_raw[0])
      ref_ph = int'((longint'(nxt) * gain_of(locked, rate_sel)) / 32768);
    else
      ref_ph = nxt;
  endtask

  task automatic drive(input bit s, input bit v);
    @(posedge clk); #1;
    sym_in = s; sym_vld = v;
    if (v) ref_sample(s);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; sym_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0; ref_reset();
    @(negedge clk);
    check(bit_vld == 1'b0, "R1", "bit_vld after reset", int'(bit_vld), 0);
    check(bit_out == 1'b0, "R1", "bit_out after reset", int'(bit_out), 0);
  endtask

  task automatic flush_and_count(input string req);
    repeat (4) drive(1'b0, 1'b0);
    @(negedge clk);
    check(exp_q.size() == 0, req, "pending decoded bits", exp_q.size(), 0);
  endtask

  // pattern: 0 random, 1 constant, 2 alternate every bit
  task automatic stream(input int nbits, input int noise_pct, input int slip_every,
                        input int gap_pct, input int pattern);
    bit lvl;
    lvl = 1'b0;
    for (int b = 0; b < nbits; b++) begin
      int len;
      case (pattern)
        1: lvl = 1'b1;
        2: lvl = ~lvl;
        default: lvl = 1'($urandom_range(0, 1));
      endcase
      len = spb_of(rate_sel);
      if (slip_every > 0 && (b % slip_every) == 0) len = len + 1;
      for (int k = 0; k < len; k++) begin
        bit s;
        s = lvl;
        if ($urandom_range(0, 99) < noise_pct) s = ~s;
        if ($urandom_range(0, 99) < gap_pct) drive(1'($urandom_range(0, 1)), 1'b0);
        drive(s, 1'b1);
      end
    end
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && bit_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected bit_vld", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(bit_out == e, cur_req, "decoded bit", int'(bit_out), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    ref_reset();
    cur_req = "R1";
    do_reset();

    // R4: noisy symbols, unlocked, middle rate
    cur_req = "R4"; rate_sel = 2'd0; locked = 1'b0; descr_en = 1'b0;
    stream(150, 10, 0, 0, 0);
    flush_and_count("R4");

    // R5: locked gain with a drifting sender
    cur_req = "R5"; locked = 1'b1;
    stream(150, 0, 5, 0, 0);
    locked = 1'b0;
    stream(60, 0, 3, 0, 0);
    flush_and_count("R5");

    // R6: descrambler from its all-ones start, fast rate, fast locked gain
    cur_req = "R6";
    do_reset();
    rate_sel = 2'd1; descr_en = 1'b1; locked = 1'b1;
    stream(300, 0, 0, 0, 0);
    flush_and_count("R6");

    // R2: slow rate with idle gaps where sym_in toggles without a strobe
    cur_req = "R2"; rate_sel = 2'd2; descr_en = 1'b0; locked = 1'b0;
    stream(60, 3, 0, 20, 0);
    flush_and_count("R2");
    rate_sel = 2'd3;
    stream(100, 0, 7, 0, 0);
    flush_and_count("R2");

    // R8: descrambler switched on and off, state held while off
    cur_req = "R8"; rate_sel = 2'd1; locked = 1'b1;
    for (int seg = 0; seg < 5; seg++) begin
      descr_en = seg[0];
      stream(40, 0, 0, 0, 0);
    end
    flush_and_count("R8");

    // R7: constant level gives ones, alternating gives zeros
    cur_req = "R7"; rate_sel = 2'd0; descr_en = 1'b0; locked = 1'b0;
    stream(80, 0, 0, 0, 1);
    stream(80, 0, 0, 0, 2);
    flush_and_count("R7");

    cur_req = "R1";
    do_reset();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule